// File: doc/BRIEF.md
# Masked Watchpoint Comparator Bank

This block holds a small set of comparators that watch the address and data activity of a processor core. Each comparator is programmed over a plain register port with a reference value, a count of low bits to ignore, and a selection of what to compare against. The watched quantity can be the instruction fetch address, the data access address, the data value of an access, or a free-running cycle count. When the selected quantity matches under the mask, the comparator raises a one-cycle match output and latches a sticky flag.

Ignoring the low N bits of both operands lets one comparator cover an aligned range of 2^N addresses. Only one comparator slot can follow the cycle counter, and only one slot can compare data values. A selection that a slot cannot perform behaves as if the slot were switched off. Logic that halts the core or emits trace consumes `match_o` and `seen_o`; that logic sits outside this block.

Top module: `wp_watch_bank`

## Requirements
- R1: After reset every match output and every sticky flag is 0, and every register reads as 0.
- R2: The register address is {slot index, selector}, with the selector in the low 2 bits: 0 = reference value (all bits), 1 = ignore count (bits [4:0]), 2 = control (kind in bits [2:0], sticky flag in bit 8, read-only). Selector 3 reads 0, and unused bits read 0. Read data is combinational while the read strobe is high.
- R3: Kind 1 (instruction address): a valid fetch whose address matches raises that slot's bit of `match_o` in the cycle after the fetch, for exactly one cycle per matching fetch. Data accesses and fetches that are not valid do not match.
- R4: Kind 2 matches only data reads (write flag 0), kind 3 only data writes (write flag 1), and kind 4 either. Each matching valid access gives one pulse.
- R5: With an ignore count of N, the low N bits of both the reference and the observed value play no part in the comparison, so the slot matches an aligned block of 2^N values.
- R6: Kind 5 (data value) compares the data value of a valid access, read or write, at any address. Only slot 1 supports it.
- R7: Kind 6 (cycle count) needs no valid strobe. It pulses in the cycle after the counter input equals the reference, and again every later time the counter equals the reference. Only slot 0 supports it.
- R8: Kind 0, kind 7, and any kind a slot does not support never produce a match.
- R9: The sticky flag sets together with the match pulse. It stays set until a read of that slot's control register, which returns the flag as set and then clears it. If a new match happens in the same cycle as that read, the flag stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_wr_en | input | 1 | Register write strobe |
| reg_rd_en | input | 1 | Register read strobe (a read of a control register clears that slot's sticky flag) |
| reg_addr | input | 4 | Register address {slot, selector} |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational |
| iaddr_valid | input | 1 | Instruction fetch valid |
| iaddr | input | 32 | Instruction fetch address |
| dacc_valid | input | 1 | Data access valid |
| dacc_write | input | 1 | Data access is a write (1) or a read (0) |
| daddr | input | 32 | Data access address |
| dvalue | input | 32 | Data value of the access |
| cyc_count | input | 32 | Current cycle counter value |
| match_o | output | 4 | Per-slot match pulse |
| seen_o | output | 4 | Per-slot sticky matched flag |

## Verification
The bench aims at the edges of the mask: addresses at both ends of a 16-byte window and just outside it. A design that masked only one operand, or masked one bit too many or too few, would match outside the window or miss an end of it. It sets each kind to the opposite direction of access and sets unsupported kinds on the wrong slots, so a slot that ignored the read/write flag or accepted a kind it lacks would pulse where it must stay silent. It also repeats the cycle-count value to confirm the pulse fires again, and it collides a control read with a new match to catch a flag that is cleared when it should be kept.

// File: rtl/wp_pkg.sv
package wp_pkg;

    typedef enum logic [2:0] {
        K_OFF   = 3'd0,
        K_INSTR = 3'd1,
        K_DRD   = 3'd2,
        K_DWR   = 3'd3,
        K_DANY  = 3'd4,
        K_DVAL  = 3'd5,
        K_CYC   = 3'd6,
        K_RSVD  = 3'd7
    } kind_e;

    localparam logic [1:0] SEL_REF  = 2'd0;
    localparam logic [1:0] SEL_IGN  = 2'd1;
    localparam logic [1:0] SEL_CTRL = 2'd2;

    localparam int SEEN_BIT = 8;

endpackage

// File: rtl/wp_match.sv
module wp_match
    import wp_pkg::*;
#(
    parameter int W       = 32,
    parameter int MW      = 5,
    parameter bit CAN_CYC = 1'b0,
    parameter bit CAN_VAL = 1'b0
) (
    input  kind_e          kind,
    input  logic [W-1:0]   ref_val,
    input  logic [MW-1:0]  nbits,
    input  logic           iaddr_valid,
    input  logic [W-1:0]   iaddr,
    input  logic           dacc_valid,
    input  logic           dacc_write,
    input  logic [W-1:0]   daddr,
    input  logic [W-1:0]   dvalue,
    input  logic [W-1:0]   cyc_count,
    output logic           hit
);

    logic [W-1:0] keep;
    logic         eq_i, eq_d, eq_v, eq_c;
    logic         cyc_ok, val_ok;

    always_comb begin
        keep = {W{1'b1}} << nbits;
        eq_i = ((iaddr     ^ ref_val) & keep) == '0;
        eq_d = ((daddr     ^ ref_val) & keep) == '0;
        eq_v = ((dvalue    ^ ref_val) & keep) == '0;
        eq_c = ((cyc_count ^ ref_val) & keep) == '0;
    end

    generate
        if (CAN_CYC) begin : g_cyc
            assign cyc_ok = eq_c;
        end else begin : g_nocyc
            assign cyc_ok = 1'b0;
        end
        if (CAN_VAL) begin : g_val
            assign val_ok = dacc_valid & eq_v;
        end else begin : g_noval
            assign val_ok = 1'b0;
        end
    endgenerate

    always_comb begin
        unique case (kind)
            K_INSTR: hit = iaddr_valid & eq_i;
            K_DRD:   hit = dacc_valid & ~dacc_write & eq_d;
            K_DWR:   hit = dacc_valid & dacc_write & eq_d;
            K_DANY:  hit = dacc_valid & eq_d;
            K_DVAL:  hit = val_ok;
            K_CYC:   hit = cyc_ok;
            default: hit = 1'b0;
        endcase
    end

endmodule

// File: rtl/wp_slot.sv
module wp_slot
    import wp_pkg::*;
#(
    parameter int W       = 32,
    parameter int MW      = 5,
    parameter bit CAN_CYC = 1'b0,
    parameter bit CAN_VAL = 1'b0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [1:0]    sel,
    input  logic [W-1:0]  wdata,
    input  logic          rd_clr,
    input  logic          iaddr_valid,
    input  logic [W-1:0]  iaddr,
    input  logic          dacc_valid,
    input  logic          dacc_write,
    input  logic [W-1:0]  daddr,
    input  logic [W-1:0]  dvalue,
    input  logic [W-1:0]  cyc_count,
    output logic [W-1:0]  ref_q,
    output logic [MW-1:0] nbits_q,
    output kind_e         kind_q,
    output logic          seen_q,
    output logic          pulse_q
);

    typedef struct packed {
        logic [W-1:0]  ref_val;
        logic [MW-1:0] nbits;
        kind_e         kind;
        logic          seen;
        logic          pulse;
    } slot_st_t;

    slot_st_t s_d, s_q;
    logic     hit;

    wp_match #(.W(W), .MW(MW), .CAN_CYC(CAN_CYC), .CAN_VAL(CAN_VAL)) u_match (
        .kind        (s_q.kind),
        .ref_val     (s_q.ref_val),
        .nbits       (s_q.nbits),
        .iaddr_valid (iaddr_valid),
        .iaddr       (iaddr),
        .dacc_valid  (dacc_valid),
        .dacc_write  (dacc_write),
        .daddr       (daddr),
        .dvalue      (dvalue),
        .cyc_count   (cyc_count),
        .hit         (hit)
    );

    always_comb begin
        s_d       = s_q;
        s_d.pulse = hit;
        if (wr_en) begin
            unique case (sel)
                SEL_REF:  s_d.ref_val = wdata;
                SEL_IGN:  s_d.nbits   = wdata[MW-1:0];
                SEL_CTRL: s_d.kind    = kind_e'(wdata[2:0]);
                default:  ;
            endcase
        end
        if (rd_clr) s_d.seen = 1'b0;
        if (hit)    s_d.seen = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign ref_q   = s_q.ref_val;
    assign nbits_q = s_q.nbits;
    assign kind_q  = s_q.kind;
    assign seen_q  = s_q.seen;
    assign pulse_q = s_q.pulse;

    // R8: a switched-off or reserved slot stays silent
    p_off_silent_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (kind_q == K_OFF || kind_q == K_RSVD) |=> !pulse_q);

    // R9: a pulse is always reflected in the sticky flag
    p_pulse_sets_seen_r9: assert property (@(posedge clk) disable iff (!rst_n)
        pulse_q |-> seen_q);

    // R9: the flag holds until a control read
    p_seen_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_q && !rd_clr) |=> seen_q);

    // R9: a control read without a new match clears the flag
    p_seen_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_clr && !hit) |=> !seen_q);

    generate
        if (!CAN_CYC) begin : g_chk_cyc
            // R7: cycle-count kind only on the counter slot
            p_no_cyc_r7: assert property (@(posedge clk) disable iff (!rst_n)
                (kind_q == K_CYC) |=> !pulse_q);
        end
        if (!CAN_VAL) begin : g_chk_val
            // R6: data-value kind only on the value slot
            p_no_val_r6: assert property (@(posedge clk) disable iff (!rst_n)
                (kind_q == K_DVAL) |=> !pulse_q);
        end
    endgenerate

endmodule

// File: rtl/wp_watch_bank.sv
module wp_watch_bank
    import wp_pkg::*;
#(
    parameter int NUM_CMP  = 4,
    parameter int ADDR_W   = 32,
    parameter int CYC_SLOT = 0,
    parameter int VAL_SLOT = 1
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                reg_wr_en,
    input  logic                                reg_rd_en,
    input  logic [$clog2(NUM_CMP)+1:0]          reg_addr,
    input  logic [ADDR_W-1:0]                   reg_wdata,
    output logic [ADDR_W-1:0]                   reg_rdata,
    input  logic                                iaddr_valid,
    input  logic [ADDR_W-1:0]                   iaddr,
    input  logic                                dacc_valid,
    input  logic                                dacc_write,
    input  logic [ADDR_W-1:0]                   daddr,
    input  logic [ADDR_W-1:0]                   dvalue,
    input  logic [ADDR_W-1:0]                   cyc_count,
    output logic [NUM_CMP-1:0]                  match_o,
    output logic [NUM_CMP-1:0]                  seen_o
);

    localparam int SLOT_W = $clog2(NUM_CMP);
    localparam int MW     = $clog2(ADDR_W);

    logic [SLOT_W-1:0] slot_idx;
    logic [1:0]        sel;

    logic [ADDR_W-1:0] ref_a   [NUM_CMP];
    logic [MW-1:0]     nbits_a [NUM_CMP];
    kind_e             kind_a  [NUM_CMP];

    assign slot_idx = reg_addr[SLOT_W+1:2];
    assign sel      = reg_addr[1:0];

    generate
        for (genvar k = 0; k < NUM_CMP; k++) begin : g_slot
            logic wr_k, clr_k;
            assign wr_k  = reg_wr_en && (slot_idx == SLOT_W'(k));
            assign clr_k = reg_rd_en && (slot_idx == SLOT_W'(k)) && (sel == SEL_CTRL);

            wp_slot #(
                .W       (ADDR_W),
                .MW      (MW),
                .CAN_CYC (k == CYC_SLOT),
                .CAN_VAL (k == VAL_SLOT)
            ) u_slot (
                .clk         (clk),
                .rst_n       (rst_n),
                .wr_en       (wr_k),
                .sel         (sel),
                .wdata       (reg_wdata),
                .rd_clr      (clr_k),
                .iaddr_valid (iaddr_valid),
                .iaddr       (iaddr),
                .dacc_valid  (dacc_valid),
                .dacc_write  (dacc_write),
                .daddr       (daddr),
                .dvalue      (dvalue),
                .cyc_count   (cyc_count),
                .ref_q       (ref_a[k]),
                .nbits_q     (nbits_a[k]),
                .kind_q      (kind_a[k]),
                .seen_q      (seen_o[k]),
                .pulse_q     (match_o[k])
            );
        end
    endgenerate

    always_comb begin
        reg_rdata = '0;
        if (reg_rd_en) begin
            unique case (sel)
                SEL_REF:  reg_rdata = ref_a[slot_idx];
                SEL_IGN:  reg_rdata[MW-1:0] = nbits_a[slot_idx];
                SEL_CTRL: begin
                    reg_rdata[2:0]      = kind_a[slot_idx];
                    reg_rdata[SEEN_BIT] = seen_o[slot_idx];
                end
                default:  reg_rdata = '0;
            endcase
        end
    end

    // R1: nothing fires in the first cycle after reset
    p_quiet_after_reset_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (match_o == '0));

    // R3: each pulse lasts one cycle unless a new event arrives
    p_single_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (match_o != '0 && !iaddr_valid && !dacc_valid && $stable(cyc_count)
         && kind_a[CYC_SLOT] != K_CYC) |=> (match_o == '0));

endmodule

// File: tb/wp_watch_bank_tb_top.sv
module wp_watch_bank_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr_en = 1'b0, reg_rd_en = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0, reg_rdata;
    logic        iaddr_valid = 1'b0, dacc_valid = 1'b0, dacc_write = 1'b0;
    logic [31:0] iaddr = '0, daddr = '0, dvalue = '0, cyc_count = '0;
    logic [3:0]  match_o, seen_o;

    int n_run = 0, n_fail = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    wp_watch_bank dut_i (
        .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_rd_en(reg_rd_en),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .iaddr_valid(iaddr_valid), .iaddr(iaddr), .dacc_valid(dacc_valid),
        .dacc_write(dacc_write), .daddr(daddr), .dvalue(dvalue),
        .cyc_count(cyc_count), .match_o(match_o), .seen_o(seen_o)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input int slot, input int sel, input logic [31:0] d);
        @(negedge clk);
        reg_wr_en = 1'b1; reg_addr = 4'(slot * 4 + sel); reg_wdata = d;
        @(negedge clk);
        reg_wr_en = 1'b0;
    endtask

    task automatic rd(input int slot, input int sel, output logic [31:0] d);
        @(negedge clk);
        reg_rd_en = 1'b1; reg_addr = 4'(slot * 4 + sel);
        #1 d = reg_rdata;
        @(negedge clk);
        reg_rd_en = 1'b0;
    endtask

    task automatic setup(input int slot, input logic [31:0] r, input int n, input int kind);
        wr(slot, 0, r); wr(slot, 1, 32'(n)); wr(slot, 2, 32'(kind));
    endtask

    // one cycle of bus activity, returns match_o after the next edge
    task automatic ev(input logic iv, input logic [31:0] ia, input logic dv, input logic dw,
                      input logic [31:0] da, input logic [31:0] dval, output logic [3:0] m);
        @(negedge clk);
        iaddr_valid = iv; iaddr = ia; dacc_valid = dv; dacc_write = dw; daddr = da; dvalue = dval;
        @(posedge clk); #1 m = match_o;
        @(negedge clk);
        iaddr_valid = 1'b0; dacc_valid = 1'b0;
    endtask

    task automatic t_reset;
        logic [31:0] d;
        chk("R1 match_o", 32'(match_o), 0);
        chk("R1 seen_o", 32'(seen_o), 0);
        for (int s = 0; s < 4; s++) begin
            for (int r = 0; r < 4; r++) begin
                rd(s, r, d);
                chk("R1 reg", d, 0);
            end
        end
    endtask

    task automatic t_regmap;
        logic [31:0] d;
        wr(3, 0, 32'hDEADBEEF); wr(3, 1, 32'hFFFFFFFF); wr(3, 2, 32'hFFFFFFFF);
        rd(3, 0, d); chk("R2 ref", d, 32'hDEADBEEF);
        rd(3, 1, d); chk("R2 ignore count", d, 32'h1F);
        rd(3, 2, d); chk("R2 control", d, 32'h7);
        rd(3, 3, d); chk("R2 unused selector", d, 0);
        wr(3, 2, 0);
    endtask

    task automatic t_iaddr;
        logic [3:0] m;
        logic [31:0] d;
        setup(2, 32'h1000_0040, 0, 1);
        ev(1, 32'h1000_0040, 0, 0, 0, 0, m); chk("R3 fetch hit", 32'(m), 32'h4);
        @(posedge clk); #1 chk("R3 one-cycle pulse", 32'(match_o), 0);
        ev(1, 32'h1000_0044, 0, 0, 0, 0, m); chk("R3 other fetch", 32'(m), 0);
        ev(0, 32'h1000_0040, 0, 0, 0, 0, m); chk("R3 not valid", 32'(m), 0);
        ev(0, 0, 1, 0, 32'h1000_0040, 0, m); chk("R3 data access ignored", 32'(m), 0);
        rd(2, 2, d);
        wr(2, 2, 0);
    endtask

    task automatic t_mask;
        logic [3:0] m;
        logic [31:0] d;
        setup(2, 32'h2000_0035, 4, 4);
        ev(0, 0, 1, 0, 32'h2000_0030, 0, m); chk("R5 window low end", 32'(m), 32'h4);
        ev(0, 0, 1, 1, 32'h2000_003F, 0, m); chk("R5 window high end", 32'(m), 32'h4);
        ev(0, 0, 1, 0, 32'h2000_0040, 0, m); chk("R5 above window", 32'(m), 0);
        ev(0, 0, 1, 0, 32'h2000_002F, 0, m); chk("R5 below window", 32'(m), 0);
        wr(2, 1, 0);
        ev(0, 0, 1, 0, 32'h2000_0030, 0, m); chk("R5 no mask exact", 32'(m), 0);
        ev(0, 0, 1, 0, 32'h2000_0035, 0, m); chk("R5 no mask equal", 32'(m), 32'h4);
        rd(2, 2, d);
        wr(2, 2, 0);
    endtask

    task automatic t_rw;
        logic [3:0] m;
        setup(3, 32'h3000_0000, 0, 2);
        ev(0, 0, 1, 0, 32'h3000_0000, 0, m); chk("R4 read kind read", 32'(m), 32'h8);
        ev(0, 0, 1, 1, 32'h3000_0000, 0, m); chk("R4 read kind write", 32'(m), 0);
        wr(3, 2, 3);
        ev(0, 0, 1, 1, 32'h3000_0000, 0, m); chk("R4 write kind write", 32'(m), 32'h8);
        ev(0, 0, 1, 0, 32'h3000_0000, 0, m); chk("R4 write kind read", 32'(m), 0);
        wr(3, 2, 4);
        ev(0, 0, 1, 0, 32'h3000_0000, 0, m); chk("R4 any kind read", 32'(m), 32'h8);
        ev(0, 0, 1, 1, 32'h3000_0000, 0, m); chk("R4 any kind write", 32'(m), 32'h8);
        wr(3, 2, 0);
    endtask

    task automatic t_value;
        logic [3:0] m;
        setup(1, 32'hCAFE_F00D, 0, 5);
        setup(2, 32'hCAFE_F00D, 0, 5);
        ev(0, 0, 1, 1, 32'h0000_1234, 32'hCAFE_F00D, m); chk("R6 value hit slot1 only", 32'(m), 32'h2);
        ev(0, 0, 1, 0, 32'h0000_9990, 32'hCAFE_F00D, m); chk("R6 value hit on read", 32'(m), 32'h2);
        ev(0, 0, 0, 0, 32'h0000_1234, 32'hCAFE_F00D, m); chk("R6 not valid", 32'(m), 0);
        wr(1, 2, 7);
        ev(0, 0, 1, 1, 32'h0000_1234, 32'hCAFE_F00D, m); chk("R8 reserved kind", 32'(m), 0);
        wr(1, 2, 0); wr(2, 2, 0);
    endtask

    task automatic t_cyc;
        setup(0, 32'd100, 0, 6);
        setup(3, 32'd100, 0, 6);
        @(negedge clk); cyc_count = 32'd99;
        @(posedge clk); #1 chk("R7 before value", 32'(match_o), 0);
        @(negedge clk); cyc_count = 32'd100;
        @(posedge clk); #1 chk("R7 equal slot0 only", 32'(match_o), 32'h1);
        @(negedge clk); cyc_count = 32'd101;
        @(posedge clk); #1 chk("R7 after value", 32'(match_o), 0);
        @(negedge clk); cyc_count = 32'hFFFF_FFFF;
        @(posedge clk); #1 chk("R7 near wrap", 32'(match_o), 0);
        @(negedge clk); cyc_count = 32'd100;
        @(posedge clk); #1 chk("R7 fires again after wrap", 32'(match_o), 32'h1);
        @(negedge clk); cyc_count = 32'd0;
        wr(0, 2, 0); wr(3, 2, 0);
    endtask

    task automatic t_sticky;
        logic [3:0] m;
        logic [31:0] d;
        rd(2, 2, d);
        setup(2, 32'h4000_0000, 0, 4);
        ev(0, 0, 1, 0, 32'h4000_0000, 0, m);
        repeat (3) @(negedge clk);
        chk("R9 flag held", 32'(seen_o[2]), 1);
        rd(2, 2, d); chk("R9 read shows flag", d, 32'h104);
        chk("R9 cleared by read", 32'(seen_o[2]), 0);
        rd(2, 2, d); chk("R9 second read", d, 32'h004);
        @(negedge clk);
        reg_rd_en = 1'b1; reg_addr = 4'(2 * 4 + 2);
        dacc_valid = 1'b1; dacc_write = 1'b1; daddr = 32'h4000_0000;
        @(posedge clk); #1 chk("R9 match wins over clear", 32'(seen_o[2]), 1);
        @(negedge clk);
        reg_rd_en = 1'b0; dacc_valid = 1'b0;
        wr(2, 2, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset;
        t_regmap;
        t_iaddr;
        t_mask;
        t_rw;
        t_value;
        t_cyc;
        t_sticky;
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        #100000;
        if (!done) begin
            n_run++; n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule